// File: doc/BRIEF.md
# Oversampling Multiprocessor Serial Port

This block is a full-duplex asynchronous serial port with non-return-to-zero framing. A 16-bit divisor sets the bit rate, and every bit lasts eight ticks of the divided clock. The receiver waits for a start bit that holds low for four ticks in a row. It then takes three samples in the middle of each later bit and keeps the majority value. Each direction has a one-word buffer in front of its shift register, so software can hand over the next word while the current one is still on the line.

Two block-addressing schemes let several nodes share one line. In address-bit mode an extra bit after the data marks the first frame of a block. In idle-line mode, a long quiet gap before a frame marks that frame as an address. A sleep control hides data frames from software, so that a node only sees address frames until software wakes it. Software reaches the block through a plain register write/read handshake with one-cycle read latency.

Transmitter states: TX_IDLE, TX_START, TX_DATA, TX_ADDR, TX_PAR, TX_STOP.
- TX_IDLE to TX_START happens on a tick while the holding word is valid, and the word moves into the shifter.
- TX_START to TX_DATA happens at the end of the bit.
- TX_DATA leaves after the last data bit, to TX_ADDR in address-bit mode, else to TX_PAR if parity is on, else to TX_STOP.
- TX_ADDR goes to TX_PAR or TX_STOP.
- TX_PAR goes to TX_STOP.
- TX_STOP returns to TX_IDLE after one or two stop bits.

Receiver states: RX_HUNT, RX_QUAL, RX_DATA, RX_ADDR, RX_PAR, RX_STOP, RX_WAIT_HIGH.
- RX_HUNT to RX_QUAL happens on the first low tick.
- RX_QUAL returns to RX_HUNT on a high tick within the first four ticks, and otherwise goes to RX_DATA at the end of the bit.
- RX_DATA, RX_ADDR and RX_PAR advance in the same way as on the transmit side.
- RX_STOP goes to RX_HUNT when the stop vote is high. When the vote is low it goes to RX_WAIT_HIGH, which returns to RX_HUNT once the line is high.

Top module: `uart_mp`

## Requirements
- R1: One bit lasts (D+1)*8 clock cycles, where D is the 16-bit divisor held at register address 1.
- R2: A start bit is accepted only after four consecutive low ticks. A shorter low pulse is ignored and the receiver goes back to hunting.
- R3: The receiver samples each bit after the start bit on its 4th, 5th and 6th ticks and keeps the 2-of-3 majority, so a single corrupted tick does not change the bit.
- R4: Control register (address 0) fields: bits [2:0] give the data length minus one (1 to 8 bits, LSB first); bit 3 enables parity; bit 4 selects odd parity (even when 0); bit 5 selects two stop bits. Received data is right-aligned, with zeros above the data length.
- R5: Control bit 6 selects address-bit mode. One extra bit follows the last data bit (1 for an address frame) and is returned in bit 8 of the receive register. Parity then covers data plus that bit.
- R6: With control bit 6 clear (idle-line mode), a frame that starts after at least 10 high bit times reads back with bit 8 set. A frame that follows closely reads back with bit 8 clear.
- R7: A received parity mismatch sets status bit 3.
- R8: A frame that completes while the receive buffer is still full sets status bit 4, and the new word is dropped.
- R9: A low first stop bit sets status bit 5 (framing).
- R10: A frame that is low from start through stop sets status bit 6 (break) as well as bit 5.
- R11: With control bit 7 (sleep) set, only frames whose bit 8 would read 1 reach the receive buffer. Other frames leave status unchanged.
- R12: A write to address 2 loads the transmit holding word (bit 8 is the address bit). The word moves to the shifter on the next tick when the shifter is idle, and the holding register can be reloaded while that word is sent. Status bit 1 shows the holding register is empty and bit 2 shows the shifter is busy.
- R13: Reading address 3 returns the received word and clears status bit 0 (receive full). Reading address 4 returns status and clears bits 3 to 6. After reset, status reads 0x0002 and the line output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
The bench builds the block with its default parameters: eight ticks per bit, a 16-bit divisor and a ten-bit idle gap. It runs almost entirely at divisor 0, so that one tick equals one clock. At that rate a whole frame takes under a hundred cycles, and every word length, parity and stop setting, both addressing schemes, sleep filtering and back-to-back frames fit into a short run. The bench switches to divisor 2 once to check the bit period. It also drives the receive line directly, with one-tick glitches and short start pulses, to reach the start-qualification and vote cases.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_ADDR, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HUNT, RX_QUAL, RX_DATA, RX_ADDR, RX_PAR, RX_STOP, RX_WAIT_HIGH
    } rx_state_e;

    // Field order matches the control register bit layout (bit 7 down to 0).
    typedef struct packed {
        logic       sleep;
        logic       addr_mode;
        logic       two_stop;
        logic       par_odd;
        logic       par_en;
        logic [2:0] len_m1;
    } cfg_t;

    typedef struct packed {
        logic       brk;
        logic       frm_err;
        logic       par_err;
        logic       addr;
        logic [7:0] data;
    } rx_frame_t;

    function automatic logic [7:0] len_mask(logic [2:0] len_m1);
        return 8'hFF >> (3'd7 - len_m1);
    endfunction

endpackage

// File: rtl/uart_mp_baud.sv
module uart_mp_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R1: with a nonzero divisor, ticks never come on adjacent cycles
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
    import uart_mp_pkg::*;
#(
    parameter int OVS    = 8,
    parameter int DATA_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cfg_t          cfg,
    input  logic          hold_valid,
    input  logic [DATA_W:0] hold_word,
    output logic          take,
    output logic          txd,
    output logic          busy
);
    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bitn_q;
    logic [DATA_W-1:0] sh_q;
    logic              addr_q, par_q, stop2_q;
    logic              bit_end;

    assign bit_end = tick && (phase_q == PH_W'(OVS-1));
    assign take    = (state_q == TX_IDLE) && tick && hold_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tick && hold_valid) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && bitn_q == BIT_W'(cfg.len_m1))
                          state_d = cfg.addr_mode ? TX_ADDR : (cfg.par_en ? TX_PAR : TX_STOP);
            TX_ADDR:  if (bit_end) state_d = cfg.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end && (!cfg.two_stop || stop2_q)) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            phase_q <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            addr_q  <= 1'b0;
            par_q   <= 1'b0;
            stop2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                sh_q    <= hold_word[DATA_W-1:0];
                addr_q  <= hold_word[DATA_W];
                par_q   <= (^(hold_word[DATA_W-1:0] & len_mask(cfg.len_m1)))
                           ^ (cfg.addr_mode & hold_word[DATA_W]) ^ cfg.par_odd;
                bitn_q  <= '0;
                stop2_q <= 1'b0;
                phase_q <= '0;
            end else if (tick && state_q != TX_IDLE) begin
                phase_q <= bit_end ? '0 : phase_q + 1'b1;
                if (bit_end && state_q == TX_DATA) begin
                    sh_q   <= sh_q >> 1;
                    bitn_q <= bitn_q + 1'b1;
                end
                if (bit_end && state_q == TX_STOP) stop2_q <= 1'b1;
            end
        end
    end

    always_comb begin
        txd = 1'b1;
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_ADDR:  txd = addr_q;
            TX_PAR:   txd = par_q;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
    end

    // R12: the shifter only leaves idle when a holding word was waiting
    p_start_needs_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == TX_IDLE && state_q == TX_START) |-> $past(hold_valid));

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
    import uart_mp_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int DATA_W    = 8,
    parameter int IDLE_BITS = 10,
    parameter int SYNC      = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  cfg_t      cfg,
    input  logic      rxd,
    output logic      frame_vld,
    output rx_frame_t frame
);
    localparam int PH_W       = $clog2(OVS);
    localparam int BIT_W      = $clog2(DATA_W);
    localparam int IDLE_TICKS = IDLE_BITS * OVS;
    localparam int IC_W       = $clog2(IDLE_TICKS + 1);
    localparam int QUAL       = OVS / 2;
    localparam int S0         = OVS / 2 - 1;

    rx_state_e         state_q, state_d;
    logic [SYNC-1:0]   sync_q;
    logic              rx_s;
    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bitn_q;
    logic [DATA_W-1:0] sh_q;
    logic [2:0]        samp_q;
    logic [IC_W-1:0]   idle_q;
    logic              blk_q, addr_q, par_q, any_hi_q;
    logic              bit_end, vote, go_qual;

    assign rx_s    = sync_q[SYNC-1];
    assign bit_end = tick && (phase_q == PH_W'(OVS-1));
    assign vote    = (samp_q[0] & samp_q[1]) | (samp_q[0] & samp_q[2]) | (samp_q[1] & samp_q[2]);
    assign go_qual = (state_q == RX_HUNT) && tick && !rx_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT:      if (tick && !rx_s) state_d = RX_QUAL;
            RX_QUAL:      if (tick && rx_s && phase_q < PH_W'(QUAL)) state_d = RX_HUNT;
                          else if (bit_end) state_d = RX_DATA;
            RX_DATA:      if (bit_end && bitn_q == BIT_W'(cfg.len_m1))
                              state_d = cfg.addr_mode ? RX_ADDR : (cfg.par_en ? RX_PAR : RX_STOP);
            RX_ADDR:      if (bit_end) state_d = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:       if (bit_end) state_d = RX_STOP;
            RX_STOP:      if (bit_end) state_d = vote ? RX_HUNT : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (tick && rx_s) state_d = RX_HUNT;
            default:      state_d = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RX_HUNT;
            sync_q    <= '1;
            phase_q   <= '0;
            bitn_q    <= '0;
            sh_q      <= '0;
            samp_q    <= '0;
            idle_q    <= '0;
            blk_q     <= 1'b0;
            addr_q    <= 1'b0;
            par_q     <= 1'b0;
            any_hi_q  <= 1'b0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            state_q   <= state_d;
            sync_q    <= {sync_q[SYNC-2:0], rxd};
            frame_vld <= 1'b0;
            if (state_q == RX_HUNT) begin
                if (go_qual) begin
                    phase_q  <= PH_W'(1);
                    blk_q    <= (idle_q >= IC_W'(IDLE_TICKS));
                    idle_q   <= '0;
                    bitn_q   <= '0;
                    sh_q     <= '0;
                    any_hi_q <= 1'b0;
                end else if (tick && idle_q < IC_W'(IDLE_TICKS)) begin
                    idle_q <= idle_q + 1'b1;
                end
            end else if (tick) begin
                phase_q <= bit_end ? '0 : phase_q + 1'b1;
                if (phase_q == PH_W'(S0))     samp_q[0] <= rx_s;
                if (phase_q == PH_W'(S0 + 1)) samp_q[1] <= rx_s;
                if (phase_q == PH_W'(S0 + 2)) samp_q[2] <= rx_s;
                if (bit_end) begin
                    unique case (state_q)
                        RX_DATA: begin
                            sh_q[bitn_q] <= vote;
                            bitn_q       <= bitn_q + 1'b1;
                            any_hi_q     <= any_hi_q | vote;
                        end
                        RX_ADDR: begin
                            addr_q   <= vote;
                            any_hi_q <= any_hi_q | vote;
                        end
                        RX_PAR: begin
                            par_q    <= vote;
                            any_hi_q <= any_hi_q | vote;
                        end
                        RX_STOP: begin
                            frame_vld     <= 1'b1;
                            frame.data    <= sh_q & len_mask(cfg.len_m1);
                            frame.addr    <= cfg.addr_mode ? addr_q : blk_q;
                            frame.par_err <= cfg.par_en &
                                             ((^(sh_q & len_mask(cfg.len_m1)))
                                              ^ (cfg.addr_mode & addr_q) ^ par_q ^ cfg.par_odd);
                            frame.frm_err <= !vote;
                            frame.brk     <= !vote && !any_hi_q;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R9: a frame reported with a bad stop bit leaves the receiver waiting for a high line
    p_bad_stop_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame.frm_err) |-> (state_q == RX_WAIT_HIGH));

    // R10: a break report always comes with a framing report
    p_break_has_framing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame.brk) |-> frame.frm_err);

endmodule

// File: rtl/uart_mp.sv
module uart_mp
    import uart_mp_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int OVS       = 8,
    parameter int DATA_W    = 8,
    parameter int IDLE_BITS = 10,
    parameter int BUS_W     = 16,
    parameter int RESET_DIV = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ser_rx,
    output logic             ser_tx
);
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_DIV  = 3'd1;
    localparam logic [2:0] A_TX   = 3'd2;
    localparam logic [2:0] A_RX   = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    cfg_t              cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W:0]   hold_q, rxbuf_q;
    logic              hold_full_q, rx_full_q;
    logic              par_q, ovr_q, frm_q, brk_q;
    logic [BUS_W-1:0]  rdata_q;
    logic              tick, take, tx_busy, frame_vld, deliver, rd_rx, rd_st;
    rx_frame_t         frame;

    uart_mp_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    uart_mp_tx #(.OVS(OVS), .DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg_q),
        .hold_valid(hold_full_q), .hold_word(hold_q), .take(take),
        .txd(ser_tx), .busy(tx_busy)
    );

    uart_mp_rx #(.OVS(OVS), .DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS), .SYNC(2)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg_q), .rxd(ser_rx),
        .frame_vld(frame_vld), .frame(frame)
    );

    assign rd_rx     = bus_rd && bus_addr == A_RX;
    assign rd_st     = bus_rd && bus_addr == A_STAT;
    assign deliver   = frame_vld && !(cfg_q.sleep && !frame.addr);
    assign bus_rdata = rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= cfg_t'(8'h07);
            div_q       <= DIV_W'(RESET_DIV);
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            rxbuf_q     <= '0;
            rx_full_q   <= 1'b0;
            par_q       <= 1'b0;
            ovr_q       <= 1'b0;
            frm_q       <= 1'b0;
            brk_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    A_CTRL:  cfg_q <= cfg_t'(bus_wdata[7:0]);
                    A_DIV:   div_q <= bus_wdata[DIV_W-1:0];
                    default: ;
                endcase
            end
            if (take) hold_full_q <= 1'b0;
            else if (bus_wr && bus_addr == A_TX && !hold_full_q) begin
                hold_q      <= bus_wdata[DATA_W:0];
                hold_full_q <= 1'b1;
            end

            if (rd_rx) rx_full_q <= 1'b0;
            if (rd_st) {par_q, ovr_q, frm_q, brk_q} <= 4'b0;
            if (deliver) begin
                if (!rx_full_q || rd_rx) begin
                    rxbuf_q   <= {frame.addr, frame.data};
                    rx_full_q <= 1'b1;
                end else begin
                    ovr_q <= 1'b1;
                end
                if (frame.par_err) par_q <= 1'b1;
                if (frame.frm_err) frm_q <= 1'b1;
                if (frame.brk)     brk_q <= 1'b1;
            end

            if (bus_rd) begin
                unique case (bus_addr)
                    A_CTRL:  rdata_q <= BUS_W'(cfg_q);
                    A_DIV:   rdata_q <= BUS_W'(div_q);
                    A_RX:    rdata_q <= BUS_W'(rxbuf_q);
                    A_STAT:  rdata_q <= BUS_W'({brk_q, frm_q, ovr_q, par_q,
                                                tx_busy, !hold_full_q, rx_full_q});
                    default: rdata_q <= '0;
                endcase
            end
        end
    end

    // R11: while asleep, only address frames can fill the receive buffer
    p_sleep_passes_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full_q) && $past(cfg_q.sleep)) |-> rxbuf_q[DATA_W]);

    // R8: overrun can only rise while the buffer was holding unread data
    p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rx_full_q));

endmodule

// File: tb/uart_mp_tb_top.sv
module uart_mp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ser_tx, ser_rx;
    logic        drv_en = 1'b0, drv_line = 1'b1;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign ser_rx = drv_en ? drv_line : ser_tx;

    uart_mp dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx)
    );

    // {ctrl[7:0], tx word[8:0], expected rx word[8:0]}
    localparam logic [25:0] VEC [6] = '{
        {8'h07, 9'h0A5, 9'h1A5},   // R4 8N1, idle gap -> address flag (R6)
        {8'h1F, 9'h03C, 9'h13C},   // R4 8 bits odd parity
        {8'h2C, 9'h0FF, 9'h11F},   // R4 5 bits even parity, 2 stop
        {8'h40, 9'h101, 9'h101},   // R5 1 bit, address bit set
        {8'h46, 9'h0D5, 9'h055},   // R5 7 bits, address bit clear
        {8'h5B, 9'h1F6, 9'h106}    // R5 4 bits odd parity, address bit set
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_rx(input string tag, output logic [15:0] st);
        st = '0;
        for (int k = 0; k < 600; k++) begin
            bus_read(3'd4, st);
            if (st[0]) break;
        end
        if (!st[0]) chk({tag, " receive timeout"}, st, 16'h0001);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drv_bit(input logic b, input bit glitch);
        for (int c = 0; c < 8; c++) begin
            drv_line = (glitch && c == 4) ? ~b : b;
            @(negedge clk);
        end
    endtask

    task automatic drv_frame(input logic [7:0] d, input bit use_par, input logic par,
                             input logic stop, input bit glitch);
        drv_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drv_bit(d[i], glitch);
        if (use_par) drv_bit(par, 1'b0);
        drv_bit(stop, 1'b0);
        drv_line = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, d;
        int cnt;
        idle(5);
        rst_n = 1'b1;
        idle(120);

        // R13 reset state
        bus_read(3'd4, st);
        chk("R13 reset status", st, 16'h0002);
        chk("R13 reset line", {15'b0, ser_tx}, 16'h0001);

        // Table of loopback vectors
        for (int i = 0; i < 6; i++) begin
            idle(100);
            bus_write(3'd0, {8'h00, VEC[i][25:18]});
            bus_write(3'd2, {7'b0, VEC[i][17:9]});
            wait_rx("R4 vector", st);
            chk("R7 R9 vector no error", {12'b0, st[6:3]}, 16'h0000);
            bus_read(3'd3, d);
            chk("R4 R5 vector data", d, {7'b0, VEC[i][8:0]});
        end

        // R1 bit period at divisor 2: start bit + low data bit0 = 48 clocks
        bus_write(3'd0, 16'h0007);
        bus_write(3'd1, 16'h0002);
        bus_write(3'd2, 16'h00FE);
        for (int k = 0; k < 200 && ser_tx; k++) @(negedge clk);
        cnt = 0;
        while (!ser_tx && cnt < 500) begin
            cnt++;
            @(negedge clk);
        end
        chk("R1 low run clocks", 16'(cnt), 16'd48);
        wait_rx("R1", st);
        bus_read(3'd3, d);
        chk("R1 data at divisor 2", d[7:0], 16'h00FE);
        bus_write(3'd1, 16'h0000);

        // R12 double buffering and R6 back-to-back block flag
        idle(100);
        bus_write(3'd2, 16'h0011);
        idle(3);
        bus_read(3'd4, st);
        chk("R12 hold empty, shifter busy", st, 16'h0006);
        bus_write(3'd2, 16'h0022);
        bus_read(3'd4, st);
        chk("R12 hold full while busy", st, 16'h0004);
        wait_rx("R12 first", st);
        bus_read(3'd3, d);
        chk("R6 first after gap is address", d, 16'h0111);
        wait_rx("R12 second", st);
        bus_read(3'd3, d);
        chk("R6 back-to-back is data", d, 16'h0022);

        // R8 overrun, R13 read clears
        idle(100);
        bus_write(3'd2, 16'h0031);
        idle(3);
        bus_write(3'd2, 16'h0032);
        idle(250);
        bus_read(3'd4, st);
        chk("R8 overrun status", st, 16'h0013);
        bus_read(3'd3, d);
        chk("R8 first word kept", d, 16'h0131);
        bus_read(3'd4, st);
        chk("R13 status cleared after reads", st, 16'h0002);

        // R11 sleep in idle-line mode
        bus_write(3'd0, 16'h0087);
        idle(100);
        bus_write(3'd2, 16'h0041);
        idle(3);
        bus_write(3'd2, 16'h0042);
        idle(250);
        bus_read(3'd4, st);
        chk("R11 idle sleep drops data frame", st, 16'h0003);
        bus_read(3'd3, d);
        chk("R11 idle sleep keeps address", d, 16'h0141);
        idle(130);
        bus_write(3'd2, 16'h0043);
        wait_rx("R6 new block", st);
        bus_read(3'd3, d);
        chk("R6 gap after frame gives address", d, 16'h0143);

        // R11 sleep in address-bit mode
        bus_write(3'd0, 16'h00C7);
        bus_write(3'd2, 16'h0044);
        idle(150);
        bus_read(3'd4, st);
        chk("R11 addr sleep ignores data frame", st, 16'h0002);
        bus_write(3'd2, 16'h0145);
        wait_rx("R11 address", st);
        bus_read(3'd3, d);
        chk("R11 addr frame presented", d, 16'h0145);
        bus_write(3'd0, 16'h0047);
        bus_write(3'd2, 16'h0046);
        wait_rx("R11 awake", st);
        bus_read(3'd3, d);
        chk("R11 data after wake", d, 16'h0046);

        // Direct line drive
        bus_write(3'd0, 16'h0007);
        drv_en = 1'b1;
        drv_line = 1'b1;
        idle(100);

        // R2 short low pulse ignored
        drv_line = 1'b0;
        idle(2);
        drv_line = 1'b1;
        idle(40);
        bus_read(3'd4, st);
        chk("R2 short pulse ignored", st, 16'h0002);
        drv_frame(8'h96, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_rx("R2", st);
        bus_read(3'd3, d);
        chk("R2 frame after rejected start", d, 16'h0096);

        // R3 one-tick glitch in every data bit
        idle(100);
        drv_frame(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_rx("R3", st);
        bus_read(3'd3, d);
        chk("R3 majority vote", d, 16'h010F);

        // R7 wrong even parity
        bus_write(3'd0, 16'h000F);
        idle(100);
        drv_frame(8'h01, 1'b1, 1'b0, 1'b1, 1'b0);
        wait_rx("R7", st);
        chk("R7 parity flag", {12'b0, st[6:3]}, 16'h0001);
        bus_read(3'd3, d);
        chk("R7 data kept", d, 16'h0101);

        // R9 framing
        bus_write(3'd0, 16'h0007);
        idle(100);
        drv_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_rx("R9", st);
        chk("R9 framing only", {12'b0, st[6:3]}, 16'h0004);
        bus_read(3'd3, d);
        chk("R9 data", d, 16'h0155);

        // R10 break
        idle(100);
        drv_line = 1'b0;
        idle(96);
        drv_line = 1'b1;
        wait_rx("R10", st);
        chk("R10 break and framing", {12'b0, st[6:3]}, 16'h000C);
        bus_read(3'd3, d);
        chk("R10 zero data", d, 16'h0100);
        idle(20);
        bus_read(3'd4, st);
        chk("R10 no second frame", st, 16'h0002);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule